// File: doc/BRIEF.md
# Two's Complement Fractional Multiplier with Rounding and Saturation

The block multiplies two signed 8-bit fractions (sign bit plus seven fraction bits, value = code / 128) and returns an 8-bit fraction in the same format, together with an overflow flag. The partial products are formed in a sign-free way: each bit is the AND of one bit from each operand. Cross terms that involve exactly one sign bit are inverted, and two constant ones are injected, so every row is added and no row is subtracted. The rows are reduced to a sum/carry pair by a stair-shaped carry-save tree. A single carry-propagate adder then forms the 16-bit product.

The 16-bit product is narrowed to 8 bits. A positive result is rounded up by one LSB when any dropped bit is set. A negative result is simply truncated. The single case that cannot be represented, the most negative code times itself, is clamped to the largest positive code and flagged.

Operands enter through a valid/ready handshake, and the result leaves through another one. A pair is taken in on a cycle where `in_valid` and `in_ready` are both high. Its result is presented on the following cycle and is held unchanged until the consumer raises `out_ready`. `in_ready` is high whenever the output register is empty or is being emptied in the same cycle. As a result, back-pressure reaches the producer with no added latency, and a continuous stream with `out_ready` held high completes one product per cycle.

Top module: `bwm_frac_mul`

## Requirements
- R1: When the exact product is positive, the result is the 8-bit code floor(P/128), where P = a×b as integers. One is added to that code when P mod 128 is non-zero.
- R2: When the exact product is negative, the result is floor(P/128) as an 8-bit two's complement code, with no correction.
- R3: For operands 0x80 and 0x80 the result is 0x7F and `out_ovf` is 1. For every other operand pair `out_ovf` is 0.
- R4: A zero product gives 0x00. A positive product whose low 7 bits are zero gives exactly P/128.
- R5: A pair is accepted on a rising edge with `in_valid` and `in_ready` both high. `out_valid` is then high after that edge, carrying that pair's result.
- R6: While `out_valid` is high and `out_ready` is low, `in_ready` is low. `out_res` and `out_ovf` hold their values, and `out_valid` stays high.
- R7: An `in_valid` pulse that arrives while `in_ready` is low has no effect on the presented result.
- R8: After reset `out_valid` is 0, `out_res` is 0x00, `out_ovf` is 0 and `in_ready` is 1.
- R9: When `out_ready` is high and no new pair is accepted, `out_valid` falls after the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand pair is present |
| in_ready | output | 1 | Block can take an operand pair this cycle |
| in_a | input | 8 | Multiplicand, signed fraction |
| in_b | input | 8 | Multiplier, signed fraction |
| out_valid | output | 1 | Result is present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_res | output | 8 | Rounded signed fraction result |
| out_ovf | output | 1 | Result was clamped because of overflow |

## Verification
Every one of the 65,536 operand pairs is streamed back to back and compared against an integer model. This exposes a wrong sign-term inversion or a misplaced constant, which shows up as errors on all operands with a sign bit set. It also exposes a dropped carry in the tree, which gives sporadic off-by-power-of-two results. The rounding corners are aimed at directly. A positive product with only the lowest bit set must give 0x01, not zero. A negative product with dropped bits must not be nudged towards zero. The 0x7F×0x7F case must land on 0x7F without wrapping, and 0x80×0x80 must clamp rather than read as −1. A stalled output is held while a second pair waits, and it must neither change nor lose the waiting pair once released.

// File: rtl/frac_mul_pkg.sv
package frac_mul_pkg;

  localparam int DEF_DW = 8;

  // number of rows produced by the sign-free partial-product generator
  function automatic int pp_rows(input int dw);
    return dw + 1;
  endfunction

  // carry-save adders in the top layer of the stair tree (three rows each)
  function automatic int tree_width(input int rows);
    return rows / 3;
  endfunction

  // words left after the top layer: two per top adder plus ungrouped rows
  function automatic int after_top(input int rows);
    return 2 * (rows / 3) + (rows % 3);
  endfunction

endpackage

// File: rtl/bw_pp_gen.sv
module bw_pp_gen #(
  parameter int DW = 8,
  localparam int W  = 2 * DW,
  localparam int NR = DW + 1
) (
  input  logic [DW-1:0] mcand,
  input  logic [DW-1:0] mplier,
  output logic [W-1:0]  rows [NR]
);

  for (genvar j = 0; j < DW; j++) begin : g_row
    always_comb begin
      rows[j] = '0;
      for (int i = 0; i < DW; i++) begin
        // cross terms with exactly one sign bit are inverted
        if ((i == DW - 1) != (j == DW - 1))
          rows[j][i+j] = ~(mcand[i] & mplier[j]);
        else
          rows[j][i+j] = mcand[i] & mplier[j];
      end
    end
  end

  // correction constants at weights DW and 2*DW-1
  always_comb begin
    rows[DW]         = '0;
    rows[DW][DW]     = 1'b1;
    rows[DW][W-1]    = 1'b1;
  end

endmodule

// File: rtl/csa_cell.sv
module csa_cell #(
  parameter int W = 16
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic [W-1:0] z,
  output logic [W-1:0] s,
  output logic [W-1:0] c
);

  logic [W-2:0] maj;

  assign s   = x ^ y ^ z;
  assign maj = (x[W-2:0] & y[W-2:0]) | (x[W-2:0] & z[W-2:0]) | (y[W-2:0] & z[W-2:0]);
  assign c   = {maj, 1'b0};

endmodule

// File: rtl/os_csa_tree.sv
module os_csa_tree
  import frac_mul_pkg::*;
#(
  parameter int NW = 9,
  parameter int W  = 16,
  localparam int G = tree_width(NW),
  localparam int R = NW - 3 * G,
  localparam int M = after_top(NW)
) (
  input  logic [W-1:0] words [NW],
  output logic [W-1:0] sum,
  output logic [W-1:0] carry
);

  logic [W-1:0] mid   [M];
  logic [W-1:0] acc_s [M-1];
  logic [W-1:0] acc_c [M-1];

  // top layer: independent adders, each taking three rows
  for (genvar g = 0; g < G; g++) begin : g_top
    csa_cell #(.W(W)) u_top (
      .x(words[3*g]), .y(words[3*g+1]), .z(words[3*g+2]),
      .s(mid[2*g]),   .c(mid[2*g+1])
    );
  end

  for (genvar r = 0; r < R; r++) begin : g_rest
    assign mid[2*G+r] = words[3*G+r];
  end

  // stair: the running sum/carry pair absorbs one word per step
  assign acc_s[0] = mid[0];
  assign acc_c[0] = mid[1];

  for (genvar k = 0; k < M - 2; k++) begin : g_stair
    csa_cell #(.W(W)) u_step (
      .x(acc_s[k]), .y(acc_c[k]), .z(mid[k+2]),
      .s(acc_s[k+1]), .c(acc_c[k+1])
    );
  end

  assign sum   = acc_s[M-2];
  assign carry = acc_c[M-2];

endmodule

// File: rtl/frac_round_sat.sv
module frac_round_sat #(
  parameter int DW = 8,
  localparam int W = 2 * DW
) (
  input  logic [W-1:0]  prod,
  output logic [DW-1:0] res,
  output logic          ovf
);

  localparam logic [DW-1:0] MAXPOS = {1'b0, {(DW-1){1'b1}}};

  logic [DW-1:0] kept;
  logic [DW-2:0] dropped;
  logic          neg;
  logic          bump;

  assign neg     = prod[W-1];
  assign kept    = prod[W-2 -: DW];
  assign dropped = prod[DW-2:0];
  // only the most negative squared reaches weight 2^(W-2) without the sign
  assign ovf     = ~prod[W-1] & prod[W-2];
  assign bump    = ~neg & (|dropped);

  always_comb begin
    if (ovf)
      res = MAXPOS;
    else if (bump)
      res = (kept == MAXPOS) ? MAXPOS : kept + 1'b1;
    else
      res = kept;
  end

endmodule

// File: rtl/bwm_frac_mul.sv
module bwm_frac_mul
  import frac_mul_pkg::*;
#(
  parameter int DW = DEF_DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_a,
  input  logic [DW-1:0] in_b,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_res,
  output logic          out_ovf
);

  localparam int W  = 2 * DW;
  localparam int NR = pp_rows(DW);

  logic [W-1:0]  rows [NR];
  logic [W-1:0]  t_sum, t_carry, prod;
  logic [DW-1:0] nxt_res;
  logic          nxt_ovf;
  logic          take;

  bw_pp_gen #(.DW(DW)) u_pp (
    .mcand(in_a), .mplier(in_b), .rows(rows)
  );

  os_csa_tree #(.NW(NR), .W(W)) u_tree (
    .words(rows), .sum(t_sum), .carry(t_carry)
  );

  assign prod = t_sum + t_carry;

  frac_round_sat #(.DW(DW)) u_rnd (
    .prod(prod), .res(nxt_res), .ovf(nxt_ovf)
  );

  assign in_ready = ~out_valid | out_ready;
  assign take     = in_valid & in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_res   <= '0;
      out_ovf   <= 1'b0;
    end else if (take) begin
      out_valid <= 1'b1;
      out_res   <= nxt_res;
      out_ovf   <= nxt_ovf;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/bwm_frac_mul_chk.sv
module bwm_frac_mul_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [DW-1:0] out_res,
  input logic          out_ovf
);

  localparam logic [DW-1:0] MAXPOS = {1'b0, {(DW-1){1'b1}}};

  assert_accept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  assert_stall_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_res) && $stable(out_ovf)));

  assert_stall_block_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  assert_ovf_clamp_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ovf) |-> (out_res == MAXPOS));

  assert_drain_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !in_valid) |=> !out_valid);

endmodule

bind bwm_frac_mul bwm_frac_mul_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_res(out_res), .out_ovf(out_ovf)
);

// File: tb/bwm_frac_mul_tb_top.sv
module bwm_frac_mul_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_a = '0;
  logic [7:0] in_b = '0;
  logic       out_valid;
  logic       out_ready = 1'b1;
  logic [7:0] out_res;
  logic       out_ovf;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  bwm_frac_mul dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_ready(out_ready),
    .out_res(out_res), .out_ovf(out_ovf)
  );

  // {a, b, expected result, expected overflow}
  localparam logic [24:0] VEC [12] = '{
    {8'h40, 8'h40, 8'h20, 1'b0},
    {8'h80, 8'h80, 8'h7F, 1'b1},
    {8'h7F, 8'h7F, 8'h7F, 1'b0},
    {8'h80, 8'h7F, 8'h81, 1'b0},
    {8'hFF, 8'h01, 8'hFF, 1'b0},
    {8'h01, 8'h01, 8'h01, 1'b0},
    {8'h00, 8'h80, 8'h00, 1'b0},
    {8'h03, 8'h05, 8'h01, 1'b0},
    {8'hFD, 8'h05, 8'hFF, 1'b0},
    {8'h80, 8'h01, 8'hFF, 1'b0},
    {8'h60, 8'hA0, 8'hB8, 1'b0},
    {8'h55, 8'h33, 8'h22, 1'b0}
  };

  function automatic logic [8:0] ref_mul(input logic [7:0] a, input logic [7:0] b);
    int ai, bi, p, q;
    logic [7:0] r;
    ai = int'($signed(a));
    bi = int'($signed(b));
    p  = ai * bi;
    if (a == 8'h80 && b == 8'h80) return {1'b1, 8'h7F};
    q = p >>> 7;
    r = q[7:0];
    if (p > 0 && (p % 128) != 0) r = (r == 8'h7F) ? 8'h7F : r + 8'd1;
    return {1'b0, r};
  endfunction

  function automatic string tag_of(input logic [7:0] a, input logic [7:0] b);
    int p;
    p = int'($signed(a)) * int'($signed(b));
    if (a == 8'h80 && b == 8'h80) return "R3";
    if (p < 0) return "R2";
    if (p > 0 && (p % 128) != 0) return "R1";
    return "R4";
  endfunction

  task automatic check(input string req, input logic [7:0] got_r, input logic got_o,
                       input logic [7:0] exp_r, input logic exp_o);
    checks++;
    if (got_r !== exp_r || got_o !== exp_o) begin
      errors++;
      $display("FAIL %s: got res=%02h ovf=%0b, expected res=%02h ovf=%0b",
               req, got_r, got_o, exp_r, exp_o);
    end
  endtask

  task automatic check_bit(input string req, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0b, expected %0b", req, got, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout, expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] pa, pb;
    logic [8:0] e;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R8: reset state
    check_bit("R8 out_valid", out_valid, 1'b0);
    check("R8", out_res, out_ovf, 8'h00, 1'b0);
    check_bit("R8 in_ready", in_ready, 1'b1);

    // table of vectors, streamed one per cycle
    for (int k = 0; k <= 12; k++) begin
      if (k > 0) begin
        check_bit("R5 out_valid", out_valid, 1'b1);
        check(tag_of(VEC[k-1][24:17], VEC[k-1][16:9]), out_res, out_ovf,
              VEC[k-1][8:1], VEC[k-1][0]);
      end
      if (k < 12) begin
        in_a = VEC[k][24:17];
        in_b = VEC[k][16:9];
        in_valid = 1'b1;
      end else begin
        in_valid = 1'b0;
      end
      @(negedge clk);
    end
    // R9: drained with out_ready high and nothing new
    check_bit("R9 out_valid", out_valid, 1'b0);

    // back-pressure: A accepted, output stalled, B waits
    in_a = 8'h55; in_b = 8'h33; in_valid = 1'b1; out_ready = 1'b0;
    @(negedge clk);
    check("R5", out_res, out_ovf, 8'h22, 1'b0);
    in_a = 8'h80; in_b = 8'h80;
    for (int s = 0; s < 3; s++) begin
      check_bit("R6 in_ready", in_ready, 1'b0);
      check_bit("R6 out_valid", out_valid, 1'b1);
      @(negedge clk);
      check("R7", out_res, out_ovf, 8'h22, 1'b0);
    end
    out_ready = 1'b1;
    @(negedge clk);
    check("R3 after stall", out_res, out_ovf, 8'h7F, 1'b1);
    in_valid = 1'b0;
    @(negedge clk);
    check_bit("R9 out_valid", out_valid, 1'b0);

    // exhaustive stream of every operand pair
    pa = '0; pb = '0;
    for (int k = 0; k <= 65536; k++) begin
      if (k > 0) begin
        e = ref_mul(pa, pb);
        check(tag_of(pa, pb), out_res, out_ovf, e[7:0], e[8]);
      end
      if (k < 65536) begin
        pa = k[15:8];
        pb = k[7:0];
        in_a = pa; in_b = pb; in_valid = 1'b1;
      end else begin
        in_valid = 1'b0;
      end
      @(negedge clk);
    end
    finish_run();
  end

endmodule